// File: doc/BRIEF.md
# Rendering Accelerator Control Register Unit

This block is the host-facing control point of a glyph rendering accelerator. The host reaches it through a 4-bit register address with separate read and write strobes. Only the low 16 bits of the 32-bit data bus are used. The block decodes four locations:

- a write-only command register;
- a read-only status word;
- a read/write interrupt mask;
- a read-only bank-occupancy word.

The bank-occupancy word is passed through from the FIFO logic.

Writing a command code can start a software reset, put the engine to sleep, wake it, or raise an interrupt. After every hardware or software reset, the block runs an internal memory-clearing phase of fixed length and reports it as busy. The interrupt output is an active-high level. It is set by a rising edge of any enabled condition and cleared when the host reads the status word.

Top module: `gray_ctrl_regs`

## Requirements
- R1: Reads return the status word at address 4'b1001, the mask at 4'b1010 and the `bank_bits` input at 4'b1011. Any other address, or `rd_en` low, reads as zero.
- R2: Status bit layout:
  - bits 15:14: `in_state`
  - bits 13:12: `out_state`
  - bit 11: `frame_end`
  - bits 10:5: `rd_count`
  - bit 3: initialisation busy
  - bit 1: halted
  - bit 0: sleep
  - bits 4 and 2: always 0.
- R3: The busy bit reads 1 for exactly INIT_CYCLES clock cycles after hardware reset is released or after a software-reset command is accepted. It then reads 0 and stays 0 until the next reset.
- R4: The mask has three fields: bit 15 (input-empty enable), bits 8:7 (output code) and bit 0 (init-done enable). Its reset value reads 16'h0181. Writes at 4'b1010 store only those bits, and all other mask bits read 0.
- R5: Interrupt conditions are:
  - input empty (`in_state`==00) when mask bit 15 is 1;
  - `out_state`==11 when the output code is 11;
  - `out_state`==01 when the output code is 01;
  - busy 0 when mask bit 0 is 1.
  A rising edge of any condition sets `irq` one clock later. Output code 00 disables the output condition.
- R6: A status read clears `irq` at the next clock edge. If a condition edge occurs in the same cycle as the read, `irq` stays set.
- R7: Command 16'h000F at address 4'b1000, accepted when not asleep, does the following:
  - restarts the busy phase;
  - restores the mask to 16'h0181;
  - clears `irq` and the halted bit;
  - rearms all edge detectors.
- R8: Command 16'hAAAA sets the sleep and halted bits and drops `clk_en`. While asleep, only 16'h5555 is accepted; it clears sleep and raises `clk_en`. Halted stays 1 until a software reset.
- R9: Command 16'h00F0, when not asleep, sets `irq` one clock later.
- R10: Command 16'h0000, unlisted command codes, and writes to read-only addresses change no state.
- R11: Bits 31:16 of `wdata` are ignored by every register, and bits 31:16 of `rdata` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| in_state | input | 2 | Input FIFO state (00 empty, 01 ready, 11 full) |
| out_state | input | 2 | Output FIFO state (00 empty, 01 ready, 11 full) |
| frame_end | input | 1 | Frame ends within the readable block |
| rd_count | input | 6 | Readable word count |
| bank_bits | input | 16 | Bank occupancy flags |
| irq | output | 1 | Interrupt request, active high |
| clk_en | output | 1 | Engine clock enable, low in sleep |

## Verification
`rdata` is combinational. It reflects the current address and the state registered at the previous edge, so it is sampled mid-cycle in the same cycle as the read. Command and mask writes, status-read clearing, and condition edges all take effect at the edge that closes their cycle. `irq`, `clk_en` and the status bits therefore show the result one cycle after the stimulus. Busy falls INIT_CYCLES edges after reset is released, and the init-done interrupt rises one edge after that. A behavioural model in the bench applies the same edge timing and is compared against all outputs two nanoseconds after every rising edge. Directed reads on top of the model check literal values.

// File: rtl/gray_ctrl_regs.sv
module gray_ctrl_regs #(
  parameter int INIT_CYCLES = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [1:0]    in_state,
  input  logic [1:0]    out_state,
  input  logic          frame_end,
  input  logic [5:0]    rd_count,
  input  logic [15:0]   bank_bits,
  output logic          irq,
  output logic          clk_en
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] INIT_LOAD = CW'(INIT_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          sleep_q, halted_q, pend_q;
  logic          en_in_q, en_init_q;
  logic [1:0]    out_code_q;
  logic [2:0]    cond_q;

  wire [15:0] code     = wdata[15:0];
  wire        cmd_wr   = wr_en && addr == 4'b1000;
  wire        msk_wr   = wr_en && addr == 4'b1010;
  wire        st_rd    = rd_en && addr == 4'b1001;
  wire        srst     = cmd_wr && !sleep_q && code == 16'h000F;
  wire        go_sleep = cmd_wr && !sleep_q && code == 16'hAAAA;
  wire        wake     = cmd_wr &&  sleep_q && code == 16'h5555;
  wire        sw_int   = cmd_wr && !sleep_q && code == 16'h00F0;
  wire        busy     = cnt_q != '0;

  wire [2:0] cond = {
    en_in_q && in_state == 2'b00,
    (out_code_q == 2'b11 && out_state == 2'b11) ||
    (out_code_q == 2'b01 && out_state == 2'b01),
    en_init_q && !busy
  };
  wire set_irq = |(cond & ~cond_q) || sw_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= INIT_LOAD; sleep_q <= 1'b0; halted_q <= 1'b0; pend_q <= 1'b0;
      en_in_q <= 1'b0; out_code_q <= 2'b11; en_init_q <= 1'b1; cond_q <= '0;
    end else if (srst) begin
      cnt_q <= INIT_LOAD; halted_q <= 1'b0; pend_q <= 1'b0;
      en_in_q <= 1'b0; out_code_q <= 2'b11; en_init_q <= 1'b1; cond_q <= '0;
    end else begin
      if (busy) cnt_q <= cnt_q - 1'b1;
      cond_q <= cond;
      pend_q <= (pend_q && !st_rd) || set_irq;
      if (msk_wr) begin
        en_in_q    <= code[15];
        out_code_q <= code[8:7];
        en_init_q  <= code[0];
      end
      if (go_sleep) begin
        sleep_q  <= 1'b1;
        halted_q <= 1'b1;
      end else if (wake) begin
        sleep_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        4'b1001: rdata[15:0] = {in_state, out_state, frame_end, rd_count,
                                1'b0, busy, 1'b0, halted_q, sleep_q};
        4'b1010: rdata[15:0] = {en_in_q, 6'b0, out_code_q, 6'b0, en_init_q};
        4'b1011: rdata[15:0] = bank_bits;
        default: rdata = '0;
      endcase
    end
  end

  assign irq    = pend_q;
  assign clk_en = !sleep_q;
endmodule

// File: rtl/gray_ctrl_regs_chk.sv
module gray_ctrl_regs_chk #(parameter int DW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    addr,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic          clk_en,
  input logic          sleep_q,
  input logic          halted_q,
  input logic          busy,
  input logic          en_init_q
);
  wire cmd   = wr_en && addr == 4'b1000;
  wire c_rst = cmd && !sleep_q && wdata[15:0] == 16'h000F;

  a_r3_busy_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !c_rst) |=> !busy);
  a_r5_init_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && en_init_q) |=> irq);
  a_r7_srst_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    c_rst |=> (busy && !irq && !halted_q));
  a_r8_sleep_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && !sleep_q && wdata[15:0] == 16'hAAAA) |=> (!clk_en && halted_q));
  a_r8_wake_keeps_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && sleep_q && wdata[15:0] == 16'h5555) |=> (clk_en && halted_q));
  a_r9_sw_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && !sleep_q && wdata[15:0] == 16'h00F0) |=> irq);
  a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:16] == '0);
endmodule

bind gray_ctrl_regs gray_ctrl_regs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .irq(irq), .clk_en(clk_en), .sleep_q(sleep_q),
  .halted_q(halted_q), .busy(busy), .en_init_q(en_init_q)
);

// File: tb/gray_ctrl_regs_tb.sv
module gray_ctrl_regs_tb;
  localparam int N = 16;
  logic clk = 0, rst_n = 0;
  logic [3:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0] in_state = 2'b01, out_state = 2'b00;
  logic frame_end = 1;
  logic [5:0] rd_count = 6'h2A;
  logic [15:0] bank_bits = 16'h5A3C;
  logic irq, clk_en;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  gray_ctrl_regs #(.INIT_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .in_state(in_state), .out_state(out_state),
    .frame_end(frame_end), .rd_count(rd_count), .bank_bits(bank_bits),
    .irq(irq), .clk_en(clk_en));

  always #10 clk = ~clk;

  // behavioural reference
  int m_cnt; bit m_sleep, m_halt, m_pend, m_m15, m_m0; bit [1:0] m_m87;
  bit p_in, p_out, p_init;

  task automatic check(input string tag, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r = 0;
    if (rd_en) case (addr)
      4'b1001: r[15:0] = {in_state, out_state, frame_end, rd_count, 1'b0,
                          1'(m_cnt > 0), 1'b0, m_halt, m_sleep};
      4'b1010: r[15:0] = {m_m15, 6'b0, m_m87, 6'b0, m_m0};
      4'b1011: r[15:0] = bank_bits;
      default: r = 0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    bit ci, co, cd, setp, cmd;
    cyc++;
    if (!rst_n) begin
      m_cnt = N; m_sleep = 0; m_halt = 0; m_pend = 0;
      m_m15 = 0; m_m87 = 3; m_m0 = 1; p_in = 0; p_out = 0; p_init = 0;
    end else begin
      ci = m_m15 && in_state == 0;
      co = (m_m87 == 3 && out_state == 3) || (m_m87 == 1 && out_state == 1);
      cd = m_m0 && m_cnt == 0;
      cmd = wr_en && addr == 4'h8;
      setp = (ci && !p_in) || (co && !p_out) || (cd && !p_init) ||
             (cmd && !m_sleep && wdata[15:0] == 16'h00F0);
      if (cmd && !m_sleep && wdata[15:0] == 16'h000F) begin
        m_cnt = N; m_halt = 0; m_pend = 0; m_m15 = 0; m_m87 = 3; m_m0 = 1;
        p_in = 0; p_out = 0; p_init = 0;
      end else begin
        m_pend = (m_pend && !(rd_en && addr == 4'h9)) || setp;
        p_in = ci; p_out = co; p_init = cd;
        if (m_cnt > 0) m_cnt--;
        if (wr_en && addr == 4'hA) begin
          m_m15 = wdata[15]; m_m87 = wdata[8:7]; m_m0 = wdata[0];
        end
        if (cmd && !m_sleep && wdata[15:0] == 16'hAAAA) begin
          m_sleep = 1; m_halt = 1;
        end else if (cmd && m_sleep && wdata[15:0] == 16'h5555) m_sleep = 0;
      end
    end
    #2;
    if (rst_n && !done) begin
      check("R5/R6 irq", {31'b0, irq}, {31'b0, m_pend});
      check("R8 clk_en", {31'b0, clk_en}, {31'b0, !m_sleep});
      check(addr == 4'h9 ? "R2 status" : addr == 4'hA ? "R4 mask" : "R1 decode",
            rdata, exp_rdata());
    end
    if (cyc > 20000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0; addr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    idle(3); rst_n = 1;
    rd(4'h9, d); check("R3 busy after reset", d[3], 1);
    check("R2 status fields", d[15:0] & 16'hFFE0, 16'h4D40);
    idle(N + 2);
    check("R5 init-done irq", irq, 1);
    rd(4'h9, d); check("R3 busy cleared", d[3], 0);
    #1 check("R6 read clears irq", irq, 0);
    rd(4'hA, d); check("R4 mask default", d, 32'h0181);
    rd(4'hB, d); check("R1 bank word", d, 32'h5A3C);
    rd(4'h0, d); check("R1 unmapped reads zero", d, 0);
    wr(4'hA, 32'hFFFF_FFFF);
    rd(4'hA, d); check("R4 mask stored bits", d, 32'h8181);
    @(negedge clk); in_state = 2'b00; idle(2);
    check("R5 input-empty irq", irq, 1);
    rd(4'h9, d); in_state = 2'b01;
    wr(4'hA, 32'h0000_0080); idle(1);
    wr(4'h8, 32'h0000_00F0);
    check("R9 software irq", irq, 1);
    @(negedge clk); addr = 4'h9; rd_en = 1; out_state = 2'b01;
    @(negedge clk); rd_en = 0; addr = 0;
    check("R6 edge during read keeps irq", irq, 1);
    rd(4'h9, d); idle(1);
    check("R6 second read clears", irq, 0);
    wr(4'h8, 32'h0000_1234); wr(4'h9, 32'h0000_000F); wr(4'h8, 32'h0);
    rd(4'h9, d); check("R10 ignored writes", d[3:0], 4'h0);
    rd(4'hA, d); check("R10 mask untouched", d, 32'h0080);
    wr(4'h8, 32'hFFFF_AAAA);
    check("R11 upper bits ignored, R8 sleep", clk_en, 0);
    rd(4'h9, d); check("R8 sleep+halted", d[1:0], 2'b11);
    wr(4'h8, 32'h0000_000F);
    rd(4'h9, d); check("R8 srst ignored asleep", d[3], 0);
    wr(4'h8, 32'h0000_5555);
    rd(4'h9, d); check("R8 wake keeps halted", d[1:0], 2'b10);
    check("R8 clk_en back", clk_en, 1);
    wr(4'h8, 32'h0000_000F);
    rd(4'h9, d); check("R7 srst busy, halt clear", d[3:0], 4'b1000);
    rd(4'hA, d); check("R7 mask default", d, 32'h0181);
    check("R11 rdata upper zero", d[31:16], 0);
    idle(N + 4);
    rd(4'h9, d); check("R3 busy ends after srst", d[3], 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule